// File: doc/BRIEF.md
# Per-Pin Secure Access Filter

This block stands between a bus port and the register file of a 16-pin I/O port. Every access arrives with a secure or non-secure attribute. A global security-enable input and a per-pin security register together decide which bits of the addressed register a non-secure access may see or change. Bits that belong to a protected pin read as zero and ignore writes. Secure accesses always pass unfiltered.

The filter is purely combinational on the access path. It turns the access into a per-bit write-enable vector and a per-bit read mask for the addressed register. The register file applies these vectors, and the block also hands back masked read data. Pin ownership follows the field width of each register: two bits per pin, one bit per pin, a set/clear pair, or four-bit function-select nibbles split across two words.

The security register itself lives inside the block. Any access may read it. Only a secure access may write it, and only while global security is enabled. It resets with all pins secure.

Top module: `sec_pin_filter`

## Requirements
- R1: After reset the security register holds 0x0000FFFF, so every pin starts secure.
- R2: For a non-secure access with global security enabled, the registers at byte offsets 0x00, 0x08 and 0x0C give pin y bits [2y+1:2y]. These bits are cleared in both `rmask_o` and `wbe_o`, and read as zero on `rdata_o`, whenever security bit y is 1.
- R3: Under the same conditions, the registers at 0x04, 0x10, 0x14, 0x1C and 0x28 give pin y bit y, which is masked in the same way. Bits [31:16] of these registers belong to no pin and are never masked.
- R4: At offset 0x18, the set/clear register, pin y owns bit y and bit y+16. Both bits are masked together.
- R5: Pins 0 to 7 own the nibble [4y+3:4y] at offset 0x20. Pins 8 to 15 own the nibble [4(y-8)+3:4(y-8)] at offset 0x24. Each nibble is masked as a unit.
- R6: A secure access is never masked, whatever the security bits hold.
- R7: With global security disabled, no access is masked. The security register reads as zero, and writes to it are ignored.
- R8: The security register (offset 0x30) changes only on a secure write while global security is enabled. It takes `wdata_i[15:0]` at the next clock edge. Bits [31:16] are not stored and read as zero.
- R9: With global security enabled, a non-secure read of offset 0x30 returns the true register value.
- R10: Offsets that map no register (0x2C, 0x34, 0x38, 0x3C) are never masked.
- R11: `wbe_o` is all zero unless `req_i` and `we_i` are both high. It is also all zero for an access to offset 0x30, because that register is held inside the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_en_i | input | 1 | Global security enable |
| req_i | input | 1 | Access valid |
| we_i | input | 1 | Access is a write |
| secure_i | input | 1 | Access carries the secure attribute |
| addr_i | input | 6 | Byte offset; bits [1:0] ignored |
| wdata_i | input | 32 | Write data |
| rdata_i | input | 32 | Raw read data from the register file |
| wbe_o | output | 32 | Per-bit write enable for the addressed register |
| rmask_o | output | 32 | Per-bit read pass mask (1 = visible) |
| rdata_o | output | 32 | Filtered read data |
| sec_pin_o | output | 16 | Stored per-pin security bits |

## Verification
The checker assumes that `sec_en_i`, `secure_i`, `addr_i` and the request signals settle before each rising edge. It compares the masks at that edge, so they must be the masks of a single access. It also assumes that the security register has no writer other than the access path. The bench meets both assumptions by driving all inputs on the falling edge and reading the combinational outputs shortly after. It holds each security-register write for exactly one rising edge before dropping the request.

// File: rtl/spf_pkg.sv
package spf_pkg;
  // word index = byte offset >> 2
  localparam int unsigned W_MODE  = 0;
  localparam int unsigned W_OTYPE = 1;
  localparam int unsigned W_SPEED = 2;
  localparam int unsigned W_PULL  = 3;
  localparam int unsigned W_IDATA = 4;
  localparam int unsigned W_ODATA = 5;
  localparam int unsigned W_SETCL = 6;
  localparam int unsigned W_LOCK  = 7;
  localparam int unsigned W_FSELL = 8;
  localparam int unsigned W_FSELH = 9;
  localparam int unsigned W_CLR   = 10;
  localparam int unsigned W_SEC   = 12;

  typedef enum logic [2:0] {
    FC_NONE, FC_W1, FC_W2, FC_PAIR, FC_NIB_LO, FC_NIB_HI, FC_SECREG
  } fclass_e;
endpackage

// File: rtl/spf_decode.sv
module spf_decode
  import spf_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic [AW-1:0] addr_i,
  output fclass_e       cls_o
);
  localparam int unsigned WIW = AW - 2;

  logic [WIW-1:0] word;
  assign word = addr_i[AW-1:2];

  always_comb begin
    unique case (int'(word))
      W_MODE, W_SPEED, W_PULL:                   cls_o = FC_W2;
      W_OTYPE, W_IDATA, W_ODATA, W_LOCK, W_CLR:  cls_o = FC_W1;
      W_SETCL:                                   cls_o = FC_PAIR;
      W_FSELL:                                   cls_o = FC_NIB_LO;
      W_FSELH:                                   cls_o = FC_NIB_HI;
      W_SEC:                                     cls_o = FC_SECREG;
      default:                                   cls_o = FC_NONE;
    endcase
  end
endmodule

// File: rtl/spf_expand.sv
module spf_expand
  import spf_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned DW    = 32
) (
  input  fclass_e          cls_i,
  input  logic [NPINS-1:0] blk_i,
  output logic [DW-1:0]    mask_o
);
  localparam int unsigned NIBS = DW / 4;

  logic [DW-1:0] pin_m [NPINS];

  for (genvar y = 0; y < NPINS; y++) begin : g_pin
    localparam int unsigned Y = y;
    logic [DW-1:0] pm;
    always_comb begin
      pm = '0;
      unique case (cls_i)
        FC_W1:  pm[Y] = blk_i[Y];
        FC_W2:  pm[2*Y +: 2] = {2{blk_i[Y]}};
        FC_PAIR: begin
          pm[Y]         = blk_i[Y];
          pm[Y + NPINS] = blk_i[Y];
        end
        FC_NIB_LO: if (Y < NIBS) pm[4*(Y % NIBS) +: 4] = {4{blk_i[Y]}};
        FC_NIB_HI: if (Y >= NIBS && Y < 2*NIBS) pm[4*(Y % NIBS) +: 4] = {4{blk_i[Y]}};
        default: pm = '0;
      endcase
    end
    assign pin_m[y] = pm;
  end

  always_comb begin
    mask_o = '0;
    for (int i = 0; i < NPINS; i++) mask_o = mask_o | pin_m[i];
  end
endmodule

// File: rtl/spf_secreg.sv
module spf_secreg #(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '1;
    else if (wr_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/sec_pin_filter.sv
module sec_pin_filter
  import spf_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sec_en_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             secure_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    rdata_i,
  output logic [DW-1:0]    wbe_o,
  output logic [DW-1:0]    rmask_o,
  output logic [DW-1:0]    rdata_o,
  output logic [NPINS-1:0] sec_pin_o
);
  fclass_e          cls;
  logic [NPINS-1:0] sec_q;
  logic [NPINS-1:0] blk;
  logic [DW-1:0]    bmask;
  logic             is_sec, sec_wr;

  spf_decode #(.AW(AW)) u_dec (.addr_i(addr_i), .cls_o(cls));

  // only non-secure traffic under global enable is filtered
  assign blk = (sec_en_i && !secure_i) ? sec_q : '0;

  spf_expand #(.NPINS(NPINS), .DW(DW)) u_exp (
    .cls_i(cls), .blk_i(blk), .mask_o(bmask)
  );

  assign is_sec = (cls == FC_SECREG);
  assign sec_wr = req_i && we_i && is_sec && secure_i && sec_en_i;

  spf_secreg #(.NPINS(NPINS)) u_sec (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(sec_wr),
    .wdata_i(wdata_i[NPINS-1:0]), .q_o(sec_q)
  );

  assign rmask_o   = is_sec ? '0 : ~bmask;
  assign wbe_o     = (req_i && we_i && !is_sec) ? ~bmask : '0;
  assign rdata_o   = is_sec ? (sec_en_i ? DW'(sec_q) : '0) : (rdata_i & rmask_o);
  assign sec_pin_o = sec_q;
endmodule

// File: rtl/spf_chk.sv
module spf_chk #(
  parameter int unsigned NPINS = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sec_en_i,
  input logic             req_i,
  input logic             we_i,
  input logic             secure_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    wbe_o,
  input logic [DW-1:0]    rmask_o,
  input logic [DW-1:0]    rdata_o,
  input logic [NPINS-1:0] sec_pin_o
);
  logic sec_hit, sec_write;
  assign sec_hit   = (addr_i[AW-1:2] == (AW-2)'(12));
  assign sec_write = req_i && we_i && secure_i && sec_en_i && sec_hit;

  // R8
  sec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_write |=> $stable(sec_pin_o));

  // R8
  sec_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_write |=> sec_pin_o == $past(wdata_i[NPINS-1:0]));

  // R6
  secure_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (secure_i && !sec_hit) |-> rmask_o == '1);

  // R7
  disabled_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_en_i && !sec_hit) |-> rmask_o == '1);

  // R7
  disabled_raz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_en_i && sec_hit) |-> rdata_o == '0);

  // R9
  sec_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_en_i && sec_hit) |-> rdata_o == DW'(sec_pin_o));

  // R11
  no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(req_i && we_i) || sec_hit) |-> wbe_o == '0);
endmodule

bind sec_pin_filter spf_chk #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sec_en_i(sec_en_i), .req_i(req_i),
  .we_i(we_i), .secure_i(secure_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .wbe_o(wbe_o), .rmask_o(rmask_o), .rdata_o(rdata_o), .sec_pin_o(sec_pin_o)
);

// File: tb/sec_pin_filter_bench.sv
module sec_pin_filter_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sec_en_i = 1'b1;
  logic        req_i = 1'b0, we_i = 1'b0, secure_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_i = '0;
  logic [31:0] wbe_o, rmask_o, rdata_o;
  logic [15:0] sec_pin_o;

  int checks = 0, fails = 0;
  logic [15:0] cur_sec;

  always #4 clk_i = ~clk_i;

  sec_pin_filter u_sec_pin_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .sec_en_i(sec_en_i), .req_i(req_i),
    .we_i(we_i), .secure_i(secure_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_i(rdata_i), .wbe_o(wbe_o), .rmask_o(rmask_o), .rdata_o(rdata_o),
    .sec_pin_o(sec_pin_o)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // blocked-bit model built from the requirement field layouts
  function automatic logic [31:0] exp_block(int w, logic [15:0] b);
    logic [31:0] m = '0;
    for (int y = 0; y < 16; y++) begin
      case (w)
        0, 2, 3:          m[2*y +: 2] = {2{b[y]}};
        1, 4, 5, 7, 10:   m[y] = b[y];
        6:                begin m[y] = b[y]; m[y+16] = b[y]; end
        8:                if (y < 8)  m[4*y +: 4] = {4{b[y]}};
        9:                if (y >= 8) m[4*(y-8) +: 4] = {4{b[y]}};
        default:          ;
      endcase
    end
    return m;
  endfunction

  function automatic string tag(int w);
    case (w)
      0, 2, 3:        return "R2";
      1, 4, 5, 7, 10: return "R3";
      6:              return "R4";
      8, 9:           return "R5";
      default:        return "R10";
    endcase
  endfunction

  task automatic access(logic wr, logic sec, logic [5:0] a, logic [31:0] wd);
    @(negedge clk_i);
    req_i = 1'b1; we_i = wr; secure_i = sec; addr_i = a; wdata_i = wd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; secure_i = 1'b0;
    #1;
  endtask

  task automatic sec_write(logic sec, logic [31:0] wd);
    access(1'b1, sec, 6'h30, wd);
    @(posedge clk_i);
    idle();
  endtask

  task automatic t_reset();
    access(1'b0, 1'b0, 6'h30, '0);
    check("R1", "sec reg after reset", rdata_o, 32'h0000_FFFF);
    check("R11", "wbe on read", wbe_o, '0);
    idle();
  endtask

  task automatic t_secreg_write();
    sec_write(1'b1, 32'hFFFF_5A3C);
    cur_sec = 16'h5A3C;
    access(1'b0, 1'b0, 6'h30, '0);
    check("R8", "secure write, upper ignored", rdata_o, 32'h0000_5A3C);
    check("R9", "non-secure read of sec reg", rdata_o, {16'h0, cur_sec});
    check("R11", "wbe at sec reg offset", wbe_o, '0);
    idle();
    sec_write(1'b0, 32'h0000_0000);
    access(1'b0, 1'b1, 6'h30, '0);
    check("R8", "non-secure write discarded", rdata_o, {16'h0, cur_sec});
    idle();
  endtask

  task automatic t_nonsec_map();
    for (int w = 0; w < 16; w++) begin
      if (w == 12) continue;
      rdata_i = 32'hFFFF_FFFF;
      access(1'b1, 1'b0, 6'(w * 4), 32'hFFFF_FFFF);
      check(tag(w), "rmask", rmask_o, ~exp_block(w, cur_sec));
      check(tag(w), "wbe", wbe_o, ~exp_block(w, cur_sec));
      check(tag(w), "rdata", rdata_o, ~exp_block(w, cur_sec));
      idle();
    end
  endtask

  task automatic t_secure_pass();
    for (int w = 0; w < 16; w++) begin
      if (w == 12) continue;
      access(1'b1, 1'b1, 6'(w * 4), '0);
      check("R6", "secure rmask", rmask_o, 32'hFFFF_FFFF);
      check("R6", "secure wbe", wbe_o, 32'hFFFF_FFFF);
      idle();
    end
  endtask

  task automatic t_disabled();
    sec_en_i = 1'b0;
    for (int w = 0; w < 12; w++) begin
      access(1'b1, 1'b0, 6'(w * 4), '0);
      check("R7", "disabled rmask", rmask_o, 32'hFFFF_FFFF);
      idle();
    end
    access(1'b0, 1'b1, 6'h30, '0);
    check("R7", "disabled sec reg reads zero", rdata_o, '0);
    idle();
    sec_write(1'b1, 32'h0000_1234);
    sec_en_i = 1'b1;
    access(1'b0, 1'b0, 6'h30, '0);
    check("R7", "disabled write ignored", rdata_o, {16'h0, cur_sec});
    idle();
  endtask

  task automatic t_no_write();
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; secure_i = 1'b1; addr_i = 6'h14; #1;
    check("R11", "read-only wbe", wbe_o, '0);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b1; #1;
    check("R11", "no request wbe", wbe_o, '0);
    idle();
  endtask

  task automatic t_edge_pins();
    sec_write(1'b1, 32'h0000_8001);
    cur_sec = 16'h8001;
    access(1'b0, 1'b0, 6'h30, '0);
    check("R8", "second pattern stored", rdata_o, 32'h0000_8001);
    idle();
    t_nonsec_map();
  endtask

  logic done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cur_sec = 16'hFFFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_nonsec_map();
    t_secreg_write();
    t_nonsec_map();
    t_secure_pass();
    t_disabled();
    t_no_write();
    t_edge_pins();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule